// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block produces the serial clock level for an I2C controller from a fast system clock. A single configuration word holds three fields: an 8-bit count for the low phase, an 8-bit count for the high phase, and a shared power-of-two prescaler exponent. Each phase of SCL lasts the matching count shifted left by the exponent, plus a fixed pipeline offset, in system clocks. With a symmetric setting the SCL frequency is the system frequency divided by twice that phase length. Typical settings target 100 kHz, and 400 kHz is the supported upper limit. To pick the fields, software takes the divisor it needs and chooses the exponent from the highest set bit above bit 7. It then shifts the divisor right by that exponent, so the count always fits in 8 bits.

A bit engine elsewhere consumes two one-cycle ticks, one marking each SCL rise and one marking each SCL fall. It can hold the clock in its current phase with a pause input. A configuration write is stored at once and reads back on the next cycle. The generator only uses the new value for the phase that begins at the next phase boundary. The phase already running keeps its length.

Top module: `scl_wave_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_out` is 1 and both ticks are 0. `cfg_rdata` holds the reset word: low count `RST_LO`, high count `RST_HI`, exponent `RST_EXP`.
- R2: The configuration word has the low count in bits 7:0, the high count in bits 15:8 and the exponent in bits 18:16. A write with `cfg_we` high is returned on `cfg_rdata` in the cycle after the write edge.
- R3: An exponent written above `EXP_MAX` is stored, read back and used as `EXP_MAX`.
- R4: Without pause, a high phase lasts (high count × 2^exponent + `OFFSET`) system clocks.
- R5: Without pause, a low phase lasts (low count × 2^exponent + `OFFSET`) system clocks.
- R6: A count of 0 acts as a count of 1, so no phase is shorter than 1 + `OFFSET` cycles. A tick is never followed by another tick in the next cycle.
- R7: `scl_fall` is high for exactly the first cycle of each low phase. `scl_rise` is high for exactly the first cycle of each high phase. The two ticks are never high together.
- R8: A phase takes its length from the configuration held just before the edge that starts it. A write during a phase does not change that phase's length.
- R9: Each cycle in which `pause` is sampled high keeps `scl_out` unchanged, raises no tick, and lengthens the current phase by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 19 | Configuration word to write |
| cfg_rdata | output | 19 | Stored configuration word (exponent after limiting) |
| pause | input | 1 | Freeze the phase counter and hold SCL |
| scl_out | output | 1 | Generated SCL level |
| scl_rise | output | 1 | One-cycle tick in the first cycle of a high phase |
| scl_fall | output | 1 | One-cycle tick in the first cycle of a low phase |

## Verification
A written word is due on `cfg_rdata` one cycle after its write edge. The bench compares it right after that edge, against its own model of the word with the exponent limited.

`scl_out` and the matching tick change together on the boundary edge. The bench samples both at the falling clock edge, half a cycle after the change. It measures each finished phase as the number of falling-edge samples at one level. The expected length comes from the configuration that was current one sample before the level changed, plus the number of paused cycles inside the phase.

Pause is driven just after a falling edge, so each pause value acts on exactly one rising edge. That keeps the count of stretched cycles exact.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;
  localparam int SWG_CNT_W = 8;
  localparam int SWG_EXP_W = 3;
  localparam int SWG_CFG_W = 2 * SWG_CNT_W + SWG_EXP_W;

  typedef struct packed {
    logic [SWG_EXP_W-1:0] expo;
    logic [SWG_CNT_W-1:0] hi_cnt;
    logic [SWG_CNT_W-1:0] lo_cnt;
  } swg_cfg_t;

  // Cycles in one phase for a given count, exponent and offset.
  function automatic int swg_phase_cycles(input int cnt, input int expo, input int offset);
    return ((cnt == 0) ? 1 : cnt) * (1 << expo) + offset;
  endfunction
endpackage

// File: rtl/swg_cfg_reg.sv
module swg_cfg_reg
  import scl_wave_pkg::*;
#(
  parameter int EXP_MAX = 5,
  parameter logic [SWG_CFG_W-1:0] RST_WORD = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SWG_CFG_W-1:0] wr_word,
  output swg_cfg_t             cfg_q
);
  localparam logic [SWG_EXP_W-1:0] EXP_CAP = SWG_EXP_W'(EXP_MAX);

  swg_cfg_t wr_fields;
  logic [SWG_EXP_W-1:0] expo_lim;

  always_comb begin
    wr_fields = swg_cfg_t'(wr_word);
    expo_lim  = (wr_fields.expo > EXP_CAP) ? EXP_CAP : wr_fields.expo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= swg_cfg_t'(RST_WORD);
    end else if (wr_en) begin
      cfg_q.expo   <= expo_lim;
      cfg_q.hi_cnt <= wr_fields.hi_cnt;
      cfg_q.lo_cnt <= wr_fields.lo_cnt;
    end
  end
endmodule

// File: rtl/swg_len_calc.sv
module swg_len_calc
  import scl_wave_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int OFFSET = 4
) (
  input  logic [SWG_CNT_W-1:0] cnt_in,
  input  logic [SWG_EXP_W-1:0] expo,
  output logic [LEN_W-1:0]     len
);
  logic [LEN_W-1:0] base;

  always_comb begin
    base = (cnt_in == '0) ? LEN_W'(1) : LEN_W'(cnt_in);
    len  = (base << expo) + LEN_W'(OFFSET);
  end
endmodule

// File: rtl/swg_phase_ctr.sv
module swg_phase_ctr #(
  parameter int LEN_W      = 14,
  parameter int RST_HI_LEN = 624
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pause,
  input  logic [LEN_W-1:0] len_lo,
  input  logic [LEN_W-1:0] len_hi,
  output logic             scl_q,
  output logic             rise_q,
  output logic             fall_q
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      remain <= LEN_W'(RST_HI_LEN - 1);
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!pause) begin
        if (remain == '0) begin
          scl_q <= ~scl_q;
          if (scl_q) begin
            remain <= len_lo - LEN_W'(1);
            fall_q <= 1'b1;
          end else begin
            remain <= len_hi - LEN_W'(1);
            rise_q <= 1'b1;
          end
        end else begin
          remain <= remain - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_wave_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int EXP_MAX = 5,
  parameter int RST_LO  = 155,
  parameter int RST_HI  = 155,
  parameter int RST_EXP = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SWG_CFG_W-1:0] cfg_wdata,
  output logic [SWG_CFG_W-1:0] cfg_rdata,
  input  logic                 pause,
  output logic                 scl_out,
  output logic                 scl_rise,
  output logic                 scl_fall
);
  localparam int LEN_W      = SWG_CNT_W + EXP_MAX + 1;
  localparam int RST_EXP_C  = (RST_EXP > EXP_MAX) ? EXP_MAX : RST_EXP;
  localparam int RST_HI_LEN = swg_phase_cycles(RST_HI, RST_EXP_C, OFFSET);
  localparam logic [SWG_CFG_W-1:0] RST_WORD =
    {SWG_EXP_W'(RST_EXP_C), SWG_CNT_W'(RST_HI), SWG_CNT_W'(RST_LO)};

  swg_cfg_t         cfg_q;
  logic [SWG_CNT_W-1:0] cnt_arr [2];
  logic [LEN_W-1:0]     len_arr [2];

  swg_cfg_reg #(
    .EXP_MAX (EXP_MAX),
    .RST_WORD(RST_WORD)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_word(cfg_wdata),
    .cfg_q  (cfg_q)
  );

  assign cnt_arr[0] = cfg_q.lo_cnt;
  assign cnt_arr[1] = cfg_q.hi_cnt;

  for (genvar g = 0; g < 2; g++) begin : g_len
    swg_len_calc #(
      .LEN_W (LEN_W),
      .OFFSET(OFFSET)
    ) u_len (
      .cnt_in(cnt_arr[g]),
      .expo  (cfg_q.expo),
      .len   (len_arr[g])
    );
  end

  swg_phase_ctr #(
    .LEN_W     (LEN_W),
    .RST_HI_LEN(RST_HI_LEN)
  ) u_phase (
    .clk   (clk),
    .rst   (rst),
    .pause (pause),
    .len_lo(len_arr[0]),
    .len_hi(len_arr[1]),
    .scl_q (scl_out),
    .rise_q(scl_rise),
    .fall_q(scl_fall)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/scl_wave_chk.sv
module scl_wave_chk
  import scl_wave_pkg::*;
#(
  parameter int EXP_MAX = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pause,
  input logic [SWG_EXP_W-1:0] rd_expo,
  input logic                 scl_out,
  input logic                 scl_rise,
  input logic                 scl_fall
);
  localparam logic [SWG_EXP_W-1:0] EXP_CAP = SWG_EXP_W'(EXP_MAX);

  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall})); // R7
  AST_FALL_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_out) |-> scl_fall); // R7
  AST_RISE_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_out) |-> scl_rise); // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (scl_rise || scl_fall) |=> !(scl_rise || scl_fall)); // R6
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    pause |=> $stable(scl_out)); // R9
  AST_PAUSE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    pause |=> !(scl_rise || scl_fall)); // R9
  AST_EXP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rd_expo <= EXP_CAP); // R3
endmodule

bind scl_wave_gen scl_wave_chk #(
  .EXP_MAX(EXP_MAX)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pause   (pause),
  .rd_expo (cfg_rdata[scl_wave_pkg::SWG_CFG_W-1 -: scl_wave_pkg::SWG_EXP_W]),
  .scl_out (scl_out),
  .scl_rise(scl_rise),
  .scl_fall(scl_fall)
);

// File: tb/test_scl_wave_gen.sv
`timescale 1ns/1ps
module test_scl_wave_gen;
  localparam int OFFSET  = 4;
  localparam int EXP_MAX = 5;
  localparam int RST_LO  = 155;
  localparam int RST_HI  = 155;
  localparam int RST_EXP = 2;
  localparam logic [18:0] RST_WORD = {3'(RST_EXP), 8'(RST_HI), 8'(RST_LO)};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic [18:0] cfg_rdata;
  logic        pause = 1'b0;
  logic        scl_out, scl_rise, scl_fall;

  int checks = 0;
  int fails  = 0;

  logic [18:0] bench_cfg;
  logic [18:0] snap;
  bit          mon_on = 1'b0;
  logic        prev_scl;
  int          cycles, paused, exp_len;
  bit          zero_flag, wrote_flag;

  always #4 clk = ~clk;

  scl_wave_gen #(
    .OFFSET(OFFSET), .EXP_MAX(EXP_MAX),
    .RST_LO(RST_LO), .RST_HI(RST_HI), .RST_EXP(RST_EXP)
  ) i_scl_wave_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pause(pause), .scl_out(scl_out),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  function automatic int exp_phase(input int cnt, input int e);
    return ((cnt == 0) ? 1 : cnt) * (1 << e) + OFFSET;
  endfunction

  function automatic logic [18:0] lim_word(input logic [18:0] w);
    logic [2:0] e;
    e = (int'(w[18:16]) > EXP_MAX) ? 3'(EXP_MAX) : w[18:16];
    return {e, w[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input bit we, input logic [18:0] w, input bit pz);
    @(negedge clk); #1;
    cfg_we = we; cfg_wdata = w; pause = pz;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (we) begin
      bench_cfg = lim_word(w);
      chk(cfg_rdata == bench_cfg, (int'(w[18:16]) > EXP_MAX) ? "R3 exponent limit" : "R2 readback",
          int'(cfg_rdata), int'(bench_cfg));
    end
  endtask

  task automatic run(input int n, input int pause_pct);
    for (int i = 0; i < n; i++) step(1'b0, '0, int'($urandom % 100) < pause_pct);
  endtask

  // Phase monitor: samples at the falling edge, half a cycle after any change.
  always @(negedge clk) begin
    if (mon_on) begin
      if (snap != bench_cfg) wrote_flag = 1'b1;
      if (scl_out != prev_scl) begin
        chk(cycles == exp_len + paused,
            $sformatf("%s%s%s%s phase length", prev_scl ? "R4" : "R5",
                      zero_flag ? " R6" : "", paused > 0 ? " R9" : "", wrote_flag ? " R8" : ""),
            cycles, exp_len + paused);
        if (scl_out == 1'b0)
          chk(scl_fall && !scl_rise, "R7 fall tick", {scl_rise, scl_fall}, 1);
        else
          chk(scl_rise && !scl_fall, "R7 rise tick", {scl_rise, scl_fall}, 2);
        if (scl_out) begin
          exp_len   = exp_phase(int'(snap[15:8]), int'(snap[18:16]));
          zero_flag = (snap[15:8] == 8'd0);
        end else begin
          exp_len   = exp_phase(int'(snap[7:0]), int'(snap[18:16]));
          zero_flag = (snap[7:0] == 8'd0);
        end
        cycles     = 1;
        paused     = 0;
        wrote_flag = 1'b0;
      end else begin
        chk(!scl_rise && !scl_fall, "R7 no tick inside phase", {scl_rise, scl_fall}, 0);
        cycles++;
        if (pause) paused++;
      end
      prev_scl = scl_out;
      snap     = bench_cfg;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: state while in reset
    chk(scl_out == 1'b1, "R1 scl during reset", int'(scl_out), 1);
    chk(!scl_rise && !scl_fall, "R1 ticks during reset", {scl_rise, scl_fall}, 0);
    chk(cfg_rdata == RST_WORD, "R1 reset word", int'(cfg_rdata), int'(RST_WORD));
    #1;
    rst        = 1'b0;
    bench_cfg  = RST_WORD;
    snap       = RST_WORD;
    prev_scl   = 1'b1;
    cycles     = 1;
    paused     = 0;
    exp_len    = exp_phase(RST_HI, RST_EXP);
    zero_flag  = 1'b0;
    wrote_flag = 1'b0;
    mon_on     = 1'b1;
    @(negedge clk);
    chk(scl_out == 1'b1 && !scl_rise && !scl_fall, "R1 first cycle after reset",
        {scl_out, scl_rise, scl_fall}, 4);
    // First high and low phases with the reset word (R4, R5)
    run(1300, 0);
    // Small asymmetric setting: high 5<<1+4=14, low 3<<1+4=10
    step(1'b1, {3'd1, 8'd5, 8'd3}, 1'b0);
    run(120, 0);
    // Zero counts: each phase 1+OFFSET
    step(1'b1, {3'd0, 8'd0, 8'd0}, 1'b0);
    run(60, 0);
    // Exponent above the limit: used as EXP_MAX (R3)
    step(1'b1, {3'd7, 8'd1, 8'd2}, 1'b0);
    run(260, 0);
    // Write in the middle of a long phase (R8)
    step(1'b1, {3'd0, 8'd40, 8'd40}, 1'b0);
    run(60, 0);
    step(1'b1, {3'd0, 8'd2, 8'd2}, 1'b0);
    run(120, 0);
    // Long pause run (R9)
    run(30, 100);
    run(60, 30);
    // Random mix of settings, writes and pauses
    for (int seg = 0; seg < 60; seg++) begin
      logic [2:0] e;
      e = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
      step(1'b1, {e, 8'($urandom % 16), 8'($urandom % 16)}, 1'b0);
      run(40 + int'($urandom % 260), int'($urandom % 40));
    end
    run(200, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule